// File: doc/BRIEF.md
# Saturating Clear-on-Read Performance Counter Bank

This block keeps five performance counters for a SONET line and path receiver. Three counters collect parity error counts: section (B1), line (B2) and path (B3). Two nibble counters record pointer increment and pointer decrement events. Upstream logic computes the parity errors and judges the pointers. It presents one error amount per frame, or one event pulse, on the block's inputs in a single cycle.

Each counter has its own set of defects that stop it from counting. The set grows from the section counter to the path counters. Every counter stops at its full-scale value and does not wrap. A register read returns the counter's value and clears the counter at the same clock edge. An event that arrives in that same cycle is kept, so nothing is lost between two reads. Both pointer nibbles share one byte-wide register, and a read of that register clears both nibbles.

Top module: `pm_counter_bank`

## Requirements
- R1: After reset every counter holds zero and `rd_data` is zero.
- R2: In each cycle, a parity counter (B1, B2, B3) adds the amount on its 4-bit error input. Values 0 to 8 are added as given, and values 9 to 15 are added as 8.
- R3: The 8-bit parity counters stop at 255 and the 4-bit pointer counters stop at 15. They never wrap.
- R4: A read with `rd_en` high returns the addressed counter's value on `rd_data` in the next cycle. That counter reads as zero afterwards. `rd_data` holds its value until the next read.
- R5: If a counted event arrives in the same cycle as a read of its counter, the counter restarts at that cycle's amount instead of zero.
- R6: The pointer register places the increment count in bits 7:4 and the decrement count in bits 3:0. One read clears both nibbles.
- R7: The B1 counter does not count while loss of signal or loss of frame is active.
- R8: The B2 counter does not count while loss of signal, loss of frame or line AIS is active.
- R9: The B3 counter and both pointer counters do not count while loss of signal, loss of frame, line AIS, loss of pointer or path AIS is active.
- R10: The addresses are 0 for B1, 1 for B2, 2 for the pointer register and 3 for B3. A read clears only the counter or counters at the addressed location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| b1_err | input | 4 | Section parity error amount this cycle |
| b2_err | input | 4 | Line parity error amount this cycle |
| b3_err | input | 4 | Path parity error amount this cycle |
| ptr_inc | input | 1 | Pointer increment event |
| ptr_dec | input | 1 | Pointer decrement event |
| def_los | input | 1 | Loss of signal defect |
| def_lof | input | 1 | Loss of frame defect |
| def_lais | input | 1 | Line AIS defect |
| def_lop | input | 1 | Loss of pointer defect |
| def_pais | input | 1 | Path AIS defect |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read value |

## Verification
The internal state of each counter is visible only through reads. A wrong count, a lost event, a missed inhibit or a wrap therefore shows up as a wrong `rd_data` value one cycle after the next read of that address. The bench reads after every stimulus burst, so a fault appears within a few cycles of its cause. The bench sweeps every error amount, all 32 defect combinations, saturation from both kinds of counter, and reads that collide with events. It compares each read against an arithmetic model.

// File: rtl/pm_pkg.sv
// Package for the performance counter bank: shared defect bundle and the
// read address map. The address values are behaviour: software decodes them.
package pm_pkg;

    // Active defects reported by the receive side.
    typedef struct packed {
        logic pais;
        logic lop;
        logic lais;
        logic lof;
        logic los;
    } pm_defects_t;

    localparam int PM_ADDR_W   = 2;
    localparam int PM_NUM_REGS = 4;
    localparam logic [PM_ADDR_W-1:0] PM_ADDR_B1  = 2'd0;
    localparam logic [PM_ADDR_W-1:0] PM_ADDR_B2  = 2'd1;
    localparam logic [PM_ADDR_W-1:0] PM_ADDR_PTR = 2'd2;
    localparam logic [PM_ADDR_W-1:0] PM_ADDR_B3  = 2'd3;

endpackage

// File: rtl/pm_sat_counter.sv
// Saturating counter with a clear-on-read input.
// Each cycle it adds `step` when `allow` is high. The sum stops at the
// all-ones value. A `clear` restarts the count from zero in that same cycle,
// so a step that coincides with a clear still counts.
// Assumes: step is already limited by the caller. Reset is synchronous, active low.
module pm_sat_counter #(
    parameter int WIDTH  = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic              allow,
    input  logic              clear,
    output logic [WIDTH-1:0]  count
);
    localparam int SUM_W = ((WIDTH > STEP_W) ? WIDTH : STEP_W) + 1;
    localparam logic [SUM_W-1:0] MAX_VAL = SUM_W'({WIDTH{1'b1}});

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] add;
    logic [SUM_W-1:0] sum;
    logic [WIDTH-1:0] nxt;

    // Next value: start from zero on clear, add the allowed step, clamp.
    always_comb begin
        base = clear ? '0 : SUM_W'(count);
        add  = allow ? SUM_W'(step) : '0;
        sum  = base + add;
        nxt  = (sum > MAX_VAL) ? {WIDTH{1'b1}} : sum[WIDTH-1:0];
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    // A full counter that is not cleared stays full.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {WIDTH{1'b1}} && !clear) |=> count == {WIDTH{1'b1}});

    // Without a clear the count never goes down, so it never wraps.
    assert_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> count >= $past(count));

    // A blocked counter that is not read keeps its value.
    assert_blocked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow && !clear) |=> $stable(count));

    // After a clear the counter holds only that cycle's allowed event.
    assert_clear_keeps_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && allow) |=> count == (($past(step) > STEP_W'({WIDTH{1'b1}})) ?
                                       {WIDTH{1'b1}} : WIDTH'($past(step))));

endmodule

// File: rtl/pm_inhibit.sv
// Inhibit decode. It turns the active defects into one count-enable per
// counter class. The sets are nested: section < line < path/pointer.
// Assumes: defect inputs are synchronous to clk.
module pm_inhibit
    import pm_pkg::*;
(
    input  pm_defects_t def,
    output logic        allow_sec,
    output logic        allow_line,
    output logic        allow_path
);
    logic sec_block, line_block, path_block;

    // Grow each block set from the previous one.
    always_comb begin
        sec_block  = def.los | def.lof;
        line_block = sec_block | def.lais;
        path_block = line_block | def.lop | def.pais;
        allow_sec  = ~sec_block;
        allow_line = ~line_block;
        allow_path = ~path_block;
    end

    // A counter further down the chain is never enabled while an earlier one is blocked.
    always_comb begin
        assert_nested_R9: assert (!(allow_path && !allow_line) && !(allow_line && !allow_sec));
    end

endmodule

// File: rtl/pm_read_port.sv
// Address-decoded read port. It captures the addressed register image into
// rd_data on a read strobe and raises the matching clear in the same cycle,
// so the capture and the clear take effect at one edge.
// Assumes: every address in the range maps to a register.
module pm_read_port #(
    parameter int ADDR_W   = 2,
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
    output logic [NUM_REGS-1:0]            clear,
    output logic [REG_W-1:0]               rd_data
);
    logic [REG_W-1:0] sel;

    // One clear line per register, raised by an address match.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign clear[i] = rd_en && (rd_addr == ADDR_W'(i));
    end

    // Pick the addressed register image.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) sel = regs[i];
    end

    // Capture the read value; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    // A read clears exactly one location; no clear happens without a read.
    assert_single_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $onehot0(clear) && clear != '0);
    assert_no_stray_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> clear == '0);
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pm_counter_bank.sv
// Performance counter bank: three saturating parity error counters and a
// pair of saturating pointer event nibbles, each with its own defect inhibit
// set, read and cleared through an address-decoded port.
// Assumes: error inputs carry one amount per frame in one cycle; amounts above
// MAX_STEP are limited to MAX_STEP. Reset is synchronous, active low.
module pm_counter_bank
    import pm_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int STEP_W   = 4,
    parameter int MAX_STEP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STEP_W-1:0]    b1_err,
    input  logic [STEP_W-1:0]    b2_err,
    input  logic [STEP_W-1:0]    b3_err,
    input  logic                 ptr_inc,
    input  logic                 ptr_dec,
    input  logic                 def_los,
    input  logic                 def_lof,
    input  logic                 def_lais,
    input  logic                 def_lop,
    input  logic                 def_pais,
    input  logic                 rd_en,
    input  logic [PM_ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]     rd_data
);
    localparam int PTR_W   = REG_W / 2;
    localparam int NUM_ERR = 3;
    localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEP);

    pm_defects_t def;
    logic allow_sec, allow_line, allow_path;
    logic [NUM_ERR-1:0][STEP_W-1:0] err_raw, err_lim;
    logic [NUM_ERR-1:0]             err_allow, err_clear;
    logic [NUM_ERR-1:0][REG_W-1:0]  err_cnt;
    logic [PTR_W-1:0] inc_cnt, dec_cnt;
    logic [PM_NUM_REGS-1:0][REG_W-1:0] regs;
    logic [PM_NUM_REGS-1:0]            clear;

    // Bundle the defect pins.
    always_comb begin
        def.los  = def_los;
        def.lof  = def_lof;
        def.lais = def_lais;
        def.lop  = def_lop;
        def.pais = def_pais;
    end

    pm_inhibit u_inhibit (
        .def        (def),
        .allow_sec  (allow_sec),
        .allow_line (allow_line),
        .allow_path (allow_path)
    );

    // Route inputs, enables and clears for the three parity counters (index 0 B1, 1 B2, 2 B3).
    always_comb begin
        err_raw   = {b3_err, b2_err, b1_err};
        err_allow = {allow_path, allow_line, allow_sec};
        err_clear = {clear[PM_ADDR_B3], clear[PM_ADDR_B2], clear[PM_ADDR_B1]};
    end

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        // Limit the per-frame amount to MAX_STEP.
        assign err_lim[i] = (err_raw[i] > STEP_LIM) ? STEP_LIM : err_raw[i];

        pm_sat_counter #(.WIDTH(REG_W), .STEP_W(STEP_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (err_lim[i]),
            .allow (err_allow[i]),
            .clear (err_clear[i]),
            .count (err_cnt[i])
        );
    end

    pm_sat_counter #(.WIDTH(PTR_W), .STEP_W(1)) u_inc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ptr_inc),
        .allow (allow_path),
        .clear (clear[PM_ADDR_PTR]),
        .count (inc_cnt)
    );

    pm_sat_counter #(.WIDTH(PTR_W), .STEP_W(1)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ptr_dec),
        .allow (allow_path),
        .clear (clear[PM_ADDR_PTR]),
        .count (dec_cnt)
    );

    // Register images in address order; the pointer pair shares one location.
    always_comb begin
        regs[PM_ADDR_B1]  = err_cnt[0];
        regs[PM_ADDR_B2]  = err_cnt[1];
        regs[PM_ADDR_PTR] = {inc_cnt, dec_cnt};
        regs[PM_ADDR_B3]  = err_cnt[2];
    end

    pm_read_port #(.ADDR_W(PM_ADDR_W), .NUM_REGS(PM_NUM_REGS), .REG_W(REG_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .regs    (regs),
        .clear   (clear),
        .rd_data (rd_data)
    );

    // Loss of signal freezes B1 unless B1 is being read.
    assert_b1_los_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (def_los && !(rd_en && rd_addr == PM_ADDR_B1)) |=> $stable(err_cnt[0]));

    // Line AIS freezes B2 unless B2 is being read.
    assert_b2_lais_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (def_lais && !(rd_en && rd_addr == PM_ADDR_B2)) |=> $stable(err_cnt[1]));

    // A pointer read empties both nibbles when no event is allowed.
    assert_ptr_pair_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == PM_ADDR_PTR && !ptr_inc && !ptr_dec) |=> (inc_cnt == '0 && dec_cnt == '0));

endmodule

// File: tb/pm_counter_bank_test.sv
module pm_counter_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] b1_err = '0, b2_err = '0, b3_err = '0;
    logic ptr_inc = 1'b0, ptr_dec = 1'b0;
    logic def_los = 1'b0, def_lof = 1'b0, def_lais = 1'b0, def_lop = 1'b0, def_pais = 1'b0;
    logic rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    int m_b1 = 0, m_b2 = 0, m_b3 = 0, m_inc = 0, m_dec = 0;

    always #2.5 clk = ~clk;

    pm_counter_bank uut (
        .clk(clk), .rst_n(rst_n),
        .b1_err(b1_err), .b2_err(b2_err), .b3_err(b3_err),
        .ptr_inc(ptr_inc), .ptr_dec(ptr_dec),
        .def_los(def_los), .def_lof(def_lof), .def_lais(def_lais),
        .def_lop(def_lop), .def_pais(def_pais),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int lim(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    function automatic int image(input int a);
        case (a)
            0: return m_b1;
            1: return m_b2;
            2: return m_inc * 16 + m_dec;
            default: return m_b3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: apply inputs, update the model at the edge, check a read one edge later.
    task automatic tick(input int e1, input int e2, input int e3, input bit pi, input bit pd,
                        input logic [4:0] d, input bit re, input int ra, input string req);
        int exp_rd;
        bit sec, line, path;
        b1_err = 4'(e1); b2_err = 4'(e2); b3_err = 4'(e3);
        ptr_inc = pi; ptr_dec = pd;
        {def_pais, def_lop, def_lais, def_lof, def_los} = d;
        rd_en = re; rd_addr = 2'(ra);
        exp_rd = image(ra);
        @(posedge clk);
        sec  = !(d[0] | d[1]);
        line = sec && !d[2];
        path = line && !(d[3] | d[4]);
        if (re && ra == 0) m_b1 = 0;
        if (re && ra == 1) m_b2 = 0;
        if (re && ra == 2) begin m_inc = 0; m_dec = 0; end
        if (re && ra == 3) m_b3 = 0;
        if (sec)  m_b1 = lim(m_b1 + lim(e1, 8), 255);
        if (line) m_b2 = lim(m_b2 + lim(e2, 8), 255);
        if (path) begin
            m_b3  = lim(m_b3 + lim(e3, 8), 255);
            m_inc = lim(m_inc + int'(pi), 15);
            m_dec = lim(m_dec + int'(pd), 15);
        end
        #1;
        if (re) check(req, int'(rd_data), exp_rd);
    endtask

    task automatic idle();
        tick(0, 0, 0, 0, 0, 5'b0, 0, 0, "");
    endtask

    task automatic rd(input int a, input string req);
        tick(0, 0, 0, 0, 0, 5'b0, 1, a, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state.
        check("R1", int'(rd_data), 0);
        for (int a = 0; a < 4; a++) rd(a, "R1");

        // R2: every error amount on each parity input, read back alone.
        for (int n = 0; n < 16; n++) begin
            tick(n, 0, 0, 0, 0, 5'b0, 0, 0, "");
            rd(0, "R2 b1");
            tick(0, n, 0, 0, 0, 5'b0, 0, 0, "");
            rd(1, "R2 b2");
            tick(0, 0, n, 0, 0, 5'b0, 0, 0, "");
            rd(3, "R2 b3");
            tick(n, n, n, 0, 0, 5'b0, 0, 0, "");
            tick(n, n, n, 0, 0, 5'b0, 0, 0, "");
            rd(0, "R2 b1 sum");
            rd(1, "R2 b2 sum");
            rd(3, "R2 b3 sum");
        end

        // R3: saturation of byte and nibble counters.
        for (int k = 0; k < 40; k++) tick(8, 15, 9, 1, 1, 5'b0, 0, 0, "");
        rd(0, "R3 b1 full");
        rd(1, "R3 b2 full");
        rd(3, "R3 b3 full");
        rd(2, "R3 ptr full");

        // R4: read clears, second read sees zero, rd_data holds between reads.
        tick(5, 0, 0, 0, 0, 5'b0, 0, 0, "");
        rd(0, "R4 value");
        idle();
        check("R4 hold", int'(rd_data), 5);
        rd(0, "R4 cleared");

        // R5: events during the clearing read.
        tick(3, 4, 6, 1, 0, 5'b0, 0, 0, "");
        tick(7, 0, 0, 0, 0, 5'b0, 1, 0, "R5 b1 read");
        tick(0, 2, 0, 0, 0, 5'b0, 1, 1, "R5 b2 read");
        tick(0, 0, 0, 1, 1, 5'b0, 1, 2, "R5 ptr read");
        tick(0, 0, 9, 0, 0, 5'b0, 1, 3, "R5 b3 read");
        for (int a = 0; a < 4; a++) rd(a, "R5 kept");

        // R6: nibble placement and joint clear.
        for (int k = 0; k < 3; k++) tick(0, 0, 0, 1, 0, 5'b0, 0, 0, "");
        for (int k = 0; k < 5; k++) tick(0, 0, 0, 0, 1, 5'b0, 0, 0, "");
        rd(2, "R6 inc hi dec lo");
        rd(2, "R6 both cleared");

        // R7 R8 R9: all defect combinations, one event burst each.
        for (int d = 0; d < 32; d++) begin
            tick(2, 3, 4, 1, 1, 5'(d), 0, 0, "");
            rd(0, "R7 b1 inhibit");
            rd(1, "R8 b2 inhibit");
            rd(3, "R9 b3 inhibit");
            rd(2, "R9 ptr inhibit");
        end

        // R10: a read clears only its own location.
        tick(1, 2, 3, 1, 1, 5'b0, 0, 0, "");
        rd(1, "R10 b2");
        rd(0, "R10 b1 kept");
        rd(3, "R10 b3 kept");
        rd(2, "R10 ptr kept");
        rd(1, "R10 b2 empty");

        idle();
        finish_run();
    end
endmodule